// File: doc/BRIEF.md
# SPI Serial Flash Slave Model

This block is a synthesizable model of a small serial flash memory as seen from the SPI slave side. A host drives chip select, serial clock and serial data in. The model decodes 8-bit opcode, address and data cycles, and serves five operations: continuous read, continuous status read, byte program, sector erase and chip erase. The array is a register file split into equal sectors. A down-counting busy timer stands in for the long program and erase times. Array size and busy durations are parameters, so simulations stay short. The real densities are 16, 32 or 64 sectors of 4096 bytes, and the parameters can be set to those values.

The pins are oversampled by a fast core clock `clk` through a short synchronizer, and every action happens on a detected SCK edge. Inputs are taken on rising SCK. SO changes after falling SCK. Both SPI mode 0 and mode 3 are therefore served. Raising CE# returns the model to standby at any point. The active-low reset pin does the same and also cancels the busy timer.

The array is updated in the cycle an operation is launched. The busy time that follows is for timing only. Opcodes are local choices: read 0x03, program 0x02, sector erase 0x20, chip erase 0x60, status 0x05. SECTORS and SECTOR_BYTES must be powers of two.

Top module: `spi_flash_model`

## Requirements
- R1: Every transfer is 8 bits, most significant bit first, sampled on rising SCK. Addresses are three bytes (24 bits). The effective address is the 24-bit value modulo the array size, and all higher bits are ignored.
- R2: Read (0x03, addr) streams the stored byte at addr, then addr+1 and so on on SO, one bit per falling SCK. After the top address it continues at address 0, until CE# rises.
- R3: Status (0x05) returns a byte repeatedly while SCK toggles. The byte is 0x01 when ready and 0x00 while a program or erase is running: bit 0 is active-low busy, and the other bits are 0.
- R4: Program (0x02, addr, data) stores the old byte AND data at addr. The device then stays busy for PROG_CYC clock cycles.
- R5: Sector erase (0x20, addr) sets every byte of the sector holding addr to 0xFF. Other sectors are unchanged.
- R6: Chip erase (0x60) sets every byte to 0xFF and reports busy until it completes.
- R7: If CE# rises before the last input bit of a program or erase, nothing changes and the device does not become busy.
- R8: While WP# is low, program and erase commands complete without effect.
- R9: While busy, any opcode other than status is ignored. An ignored read returns 0x00, and an ignored program has no effect.
- R10: Holding RESET# low returns the device to standby: SO is released and busy is cleared.
- R11: SO is enabled (so_oe=1) only while CE# is low; with CE# high, so_oe is 0.
- R12: Frames work identically with SCK idling low (mode 0) and idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock, much faster than SCK |
| reset_n | input | 1 | Active-low hardware reset to standby |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| ce_n | input | 1 | Active-low chip enable, frames an instruction |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out (0 when not streaming) |
| so_oe | output | 1 | Output enable for SO; low means high impedance |

## Verification
A pin change reaches the decoder after the synchronizer stages plus one edge-detect register. SO therefore moves about four core clocks after a falling SCK edge. The bench holds each SCK phase for eight core clocks and reads SO at the end of the low phase, just before the next rising edge. Busy begins one core clock after the final input bit of a command. A status frame issued straight after the command therefore reports 0x00 because it finishes well inside the shortest busy time. Completion is awaited by polling status rather than by counting cycles. Array contents are checked only after ready is seen, against a bench-side image updated with AND for program and 0xFF fill for erase.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_CMD,
    FS_ADDR,
    FS_DATA,
    FS_RDOUT,
    FS_STOUT,
    FS_SKIP
  } fstate_e;

  typedef enum logic [1:0] {
    JOB_NONE,
    JOB_PROG,
    JOB_SECT,
    JOB_CHIP
  } job_e;

  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'h20;
  localparam logic [7:0] OP_CERASE = 8'h60;
  localparam logic [7:0] OP_STATUS = 8'h05;

  // Bit 0 is high when ready, low when busy; other bits are zero.
  function automatic logic [7:0] status_byte(input logic busy);
    return {7'b0, ~busy};
  endfunction

  // A program can only clear bits.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b,
                                            input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/sfm_pin_sync.sv
module sfm_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic ce_n,
  input  logic si,
  input  logic wp_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic ce_high,
  output logic si_s,
  output logic wp_s
);
  // Pin order in each stage: {sck, ce_n, si, wp_n}
  localparam logic [3:0] IDLE_PINS = 4'b0101;

  logic [3:0] pipe [STAGES];
  logic [3:0] tail;
  logic       sck_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= IDLE_PINS;
      sck_last <= 1'b0;
    end else begin
      pipe[0] <= {sck, ce_n, si, wp_n};
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
      sck_last <= pipe[STAGES-1][3];
    end
  end

  assign tail     = pipe[STAGES-1];
  assign sck_rise = tail[3] & ~sck_last;
  assign sck_fall = ~tail[3] & sck_last;
  assign ce_high  = tail[2];
  assign si_s     = tail[1];
  assign wp_s     = tail[0];

endmodule

// File: rtl/sfm_frame_ctl.sv
module sfm_frame_ctl
  import sfm_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_high,
  input  logic          si_s,
  input  logic          wp_s,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          busy,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          so_bit,
  output logic          so_active,
  output logic          job_valid,
  output job_e          job_kind,
  output logic [AW-1:0] job_addr,
  output logic [7:0]    job_data
);
  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  fstate_e     state;
  logic [5:0]  bit_cnt;
  logic [7:0]  shreg;
  logic [7:0]  opcode;
  logic [23:0] addr_sh;
  logic [2:0]  obit;
  logic [AW-1:0] out_addr;

  logic [7:0]  sh_nx;
  logic [23:0] addr_nx;
  logic [7:0]  cur_byte;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return (a == TOP_ADDR) ? '0 : a + 1'b1;
  endfunction

  function automatic logic [AW-1:0] trunc_addr(input logic [23:0] a);
    return a[AW-1:0];
  endfunction

  assign sh_nx    = {shreg[6:0], si_s};
  assign addr_nx  = {addr_sh[15:0], sh_nx};
  assign cur_byte = (state == FS_STOUT) ? status_byte(busy) : rd_data;
  assign rd_addr  = out_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= FS_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      opcode    <= '0;
      addr_sh   <= '0;
      obit      <= '0;
      out_addr  <= '0;
      so_bit    <= 1'b0;
      job_valid <= 1'b0;
      job_kind  <= JOB_NONE;
      job_addr  <= '0;
      job_data  <= '0;
    end else begin
      job_valid <= 1'b0;
      if (ce_high) begin
        state   <= FS_IDLE;
        bit_cnt <= '0;
        obit    <= '0;
        so_bit  <= 1'b0;
      end else if (state == FS_IDLE) begin
        state   <= FS_CMD;
        bit_cnt <= '0;
        obit    <= '0;
      end else begin
        if (sck_rise && (state == FS_CMD || state == FS_ADDR || state == FS_DATA)) begin
          shreg   <= sh_nx;
          bit_cnt <= bit_cnt + 6'd1;
          case (state)
            FS_CMD: if (bit_cnt == 6'd7) begin
              opcode <= sh_nx;
              if (sh_nx == OP_STATUS) begin
                state <= FS_STOUT;
              end else if (busy) begin
                state <= FS_SKIP;
              end else if (sh_nx == OP_CERASE) begin
                state     <= FS_SKIP;
                job_valid <= wp_s;
                job_kind  <= JOB_CHIP;
                job_addr  <= '0;
              end else if (sh_nx == OP_READ || sh_nx == OP_PROG || sh_nx == OP_SERASE) begin
                state <= FS_ADDR;
              end else begin
                state <= FS_SKIP;
              end
            end
            FS_ADDR: if (bit_cnt[2:0] == 3'd7) begin
              addr_sh <= addr_nx;
              if (bit_cnt == 6'd31) begin
                case (opcode)
                  OP_READ: begin
                    state    <= FS_RDOUT;
                    out_addr <= trunc_addr(addr_nx);
                  end
                  OP_SERASE: begin
                    state     <= FS_SKIP;
                    job_valid <= wp_s;
                    job_kind  <= JOB_SECT;
                    job_addr  <= trunc_addr(addr_nx);
                  end
                  default: state <= FS_DATA;
                endcase
              end
            end
            FS_DATA: if (bit_cnt == 6'd39) begin
              state     <= FS_SKIP;
              job_valid <= wp_s;
              job_kind  <= JOB_PROG;
              job_addr  <= trunc_addr(addr_sh);
              job_data  <= sh_nx;
            end
            default: ;
          endcase
        end
        if (sck_fall && (state == FS_RDOUT || state == FS_STOUT)) begin
          so_bit <= cur_byte[3'd7 - obit];
          obit   <= obit + 3'd1;
          if (obit == 3'd7 && state == FS_RDOUT) out_addr <= next_addr(out_addr);
        end
      end
    end
  end

  assign so_active = (state != FS_IDLE);

endmodule

// File: rtl/sfm_store.sv
module sfm_store
  import sfm_pkg::*;
#(
  parameter int SECTORS      = 4,
  parameter int SECTOR_BYTES = 64,
  parameter int PROG_CYC     = 600,
  parameter int SERASE_CYC   = 3000,
  parameter int CERASE_CYC   = 9000,
  localparam int MEM_BYTES   = SECTORS * SECTOR_BYTES,
  localparam int AW          = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          job_valid,
  input  job_e          job_kind,
  input  logic [AW-1:0] job_addr,
  input  logic [7:0]    job_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy
);
  localparam int SW     = $clog2(SECTOR_BYTES);
  localparam int MAXCYC = (CERASE_CYC > SERASE_CYC) ?
                          ((CERASE_CYC > PROG_CYC) ? CERASE_CYC : PROG_CYC) :
                          ((SERASE_CYC > PROG_CYC) ? SERASE_CYC : PROG_CYC);
  localparam int TW     = $clog2(MAXCYC + 1);

  logic [7:0]    mem [MEM_BYTES];
  logic [TW-1:0] remain;

  function automatic logic [AW-1:0] sector_of(input logic [AW-1:0] a);
    return a >> SW;
  endfunction

  function automatic logic [TW-1:0] busy_len(input job_e k);
    case (k)
      JOB_PROG: return TW'(PROG_CYC);
      JOB_SECT: return TW'(SERASE_CYC);
      JOB_CHIP: return TW'(CERASE_CYC);
      default:  return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (job_valid) begin
      for (int i = 0; i < MEM_BYTES; i++) begin
        case (job_kind)
          JOB_PROG: if (AW'(i) == job_addr) mem[i] <= prog_merge(mem[i], job_data);
          JOB_SECT: if (sector_of(AW'(i)) == sector_of(job_addr)) mem[i] <= 8'hFF;
          JOB_CHIP: mem[i] <= 8'hFF;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               remain <= '0;
    else if (job_valid)       remain <= busy_len(job_kind);
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign busy    = (remain != '0);
  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/spi_flash_model.sv
module spi_flash_model
  import sfm_pkg::*;
#(
  parameter int SECTORS      = 4,
  parameter int SECTOR_BYTES = 64,
  parameter int PROG_CYC     = 600,
  parameter int SERASE_CYC   = 3000,
  parameter int CERASE_CYC   = 9000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic reset_n,
  input  logic sck,
  input  logic si,
  input  logic ce_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int MEM_BYTES = SECTORS * SECTOR_BYTES;
  localparam int AW        = $clog2(MEM_BYTES);

  logic          sck_rise, sck_fall, ce_s, si_s, wp_s;
  logic          busy;
  logic          job_valid;
  job_e          job_kind;
  logic [AW-1:0] job_addr, rd_addr;
  logic [7:0]    job_data, rd_data;
  logic          so_bit, so_active;

  sfm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(reset_n), .sck(sck), .ce_n(ce_n), .si(si), .wp_n(wp_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .ce_high(ce_s), .si_s(si_s), .wp_s(wp_s)
  );

  sfm_frame_ctl #(.AW(AW)) u_ctl (
    .clk(clk), .rst_n(reset_n), .ce_high(ce_s), .si_s(si_s), .wp_s(wp_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .busy(busy), .rd_data(rd_data),
    .rd_addr(rd_addr), .so_bit(so_bit), .so_active(so_active),
    .job_valid(job_valid), .job_kind(job_kind), .job_addr(job_addr), .job_data(job_data)
  );

  sfm_store #(
    .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES),
    .PROG_CYC(PROG_CYC), .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC)
  ) u_store (
    .clk(clk), .rst_n(reset_n), .job_valid(job_valid), .job_kind(job_kind),
    .job_addr(job_addr), .job_data(job_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  assign so    = so_active & so_bit;
  assign so_oe = so_active;

endmodule

// File: rtl/sfm_chk.sv
module sfm_chk (
  input logic clk,
  input logic reset_n,
  input logic ce_s,
  input logic busy,
  input logic job_valid,
  input logic so,
  input logic so_oe
);

  AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!reset_n)
    job_valid |=> busy); // R4

  AST_NO_LAUNCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!reset_n)
    busy |-> !job_valid); // R9

  AST_CE_HIGH_RELEASES_SO: assert property (@(posedge clk) disable iff (!reset_n)
    ce_s |=> !so_oe); // R11

  AST_SO_LOW_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!reset_n)
    !so_oe |-> !so); // R11

  AST_RESET_TO_STANDBY: assert property (@(posedge clk)
    !reset_n |=> (!busy && !so_oe)); // R10

endmodule

bind spi_flash_model sfm_chk u_chk (
  .clk(clk), .reset_n(reset_n), .ce_s(ce_s), .busy(busy),
  .job_valid(job_valid), .so(so), .so_oe(so_oe)
);

// File: tb/spi_flash_model_tb_top.sv
module spi_flash_model_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int SECTORS    = 4;
  localparam int SBYTES     = 64;
  localparam int MEM        = SECTORS * SBYTES;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic reset_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, ce_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  logic mode3 = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] em [MEM];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_model #(
    .SECTORS(SECTORS), .SECTOR_BYTES(SBYTES),
    .PROG_CYC(600), .SERASE_CYC(3000), .CERASE_CYC(9000), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .reset_n(reset_n), .sck(sck), .si(si), .ce_n(ce_n),
    .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  function automatic int eff(input logic [23:0] a);
    return int'(a) % MEM;
  endfunction

  function automatic int sect(input int a);
    return a / SBYTES;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic frame_begin();
    sck = mode3; half();
    ce_n = 1'b0; half(); half();
  endtask

  task automatic frame_end();
    sck = mode3; half();
    ce_n = 1'b1; half(); half();
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      sck = 1'b0; si = tx[i]; half();
      rx[i] = so;
      sck = 1'b1; half();
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] d;
    xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
  endtask

  task automatic get_status(output logic [7:0] s);
    logic [7:0] d;
    frame_begin(); xfer(8'h05, d); xfer(8'h00, s); frame_end();
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int n = 0; n < 200; n++) begin
      get_status(s);
      if (s[0]) return;
    end
    chk("R3 ready never seen", 32'd0, 32'd1);
  endtask

  task automatic do_prog(input logic [23:0] a, input logic [7:0] v);
    logic [7:0] d;
    frame_begin(); xfer(8'h02, d); send_addr(a); xfer(v, d); frame_end();
  endtask

  task automatic do_serase(input logic [23:0] a);
    logic [7:0] d;
    frame_begin(); xfer(8'h20, d); send_addr(a); frame_end();
  endtask

  task automatic do_cerase();
    logic [7:0] d;
    frame_begin(); xfer(8'h60, d); frame_end();
  endtask

  // Reads n bytes starting at a and compares each with the bench image.
  task automatic read_cmp(input string tag, input logic [23:0] a, input int n);
    logic [7:0] d;
    int p;
    p = eff(a);
    frame_begin(); xfer(8'h03, d); send_addr(a);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, d);
      chk(tag, {24'd0, d}, {24'd0, em[p]});
      p = (p + 1) % MEM;
    end
    frame_end();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    logic [23:0] a24;
    logic [7:0] v;
    int a, ref_a, seed;
    seed = int'($urandom(32'h5EED));

    // Reset state: SO released, not busy.
    repeat (5) @(posedge clk); #1;
    chk("R10 so_oe in reset", {31'd0, so_oe}, 32'd0);
    reset_n = 1'b1; half();
    chk("R11 so_oe with CE# high", {31'd0, so_oe}, 32'd0);
    frame_begin();
    chk("R11 so_oe with CE# low", {31'd0, so_oe}, 32'd1);
    xfer(8'h05, d);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, s);
      chk("R3 ready status repeats", {24'd0, s}, 32'h01);
    end
    frame_end();

    // Chip erase.
    do_cerase();
    get_status(s);
    chk("R3/R6 busy status after chip erase", {24'd0, s}, 32'h00);
    wait_ready();
    for (int i = 0; i < MEM; i++) em[i] = 8'hFF;
    read_cmp("R6 erased", 24'd17, 4);
    read_cmp("R2 wrap read erased", 24'(MEM - 2), 4);

    // Random programs, mixed modes, random upper address bits.
    for (int it = 0; it < 16; it++) begin
      mode3 = 1'($urandom);
      a24 = 24'($urandom);
      v = 8'($urandom);
      a = eff(a24);
      do_prog(a24, v);
      em[a] = em[a] & v;
      get_status(s);
      chk("R3/R4 busy after program", {24'd0, s}, 32'h00);
      wait_ready();
      read_cmp("R1/R4/R12 program readback", {8'($urandom), 16'(a)}, 2);
    end
    mode3 = 1'b0;

    // AND semantics on a second program.
    do_prog(24'd5, 8'hF0); wait_ready();
    do_prog(24'd5, 8'h3C); wait_ready();
    em[5] = em[5] & 8'hF0 & 8'h3C;
    read_cmp("R4 program ANDs", 24'd5, 1);

    // Wrap from top to zero with known data, in mode 3.
    mode3 = 1'b1;
    do_prog(24'(MEM - 1), 8'hA5); wait_ready(); em[MEM-1] = em[MEM-1] & 8'hA5;
    do_prog(24'd0, 8'h5A); wait_ready(); em[0] = em[0] & 8'h5A;
    read_cmp("R2/R12 wrap top to zero", 24'(MEM - 1), 3);
    mode3 = 1'b0;

    // Fill sector 1 and 2 bytes, then erase sector 1 and dump the array.
    do_prog(24'(SBYTES + 3), 8'h11); wait_ready(); em[SBYTES+3] = em[SBYTES+3] & 8'h11;
    do_prog(24'(2*SBYTES + 4), 8'h22); wait_ready(); em[2*SBYTES+4] = em[2*SBYTES+4] & 8'h22;
    do_serase(24'(SBYTES + 40));
    for (int i = 0; i < MEM; i++) if (sect(i) == 1) em[i] = 8'hFF;
    wait_ready();
    read_cmp("R5 sector erase dump", 24'd0, MEM);

    // Abort: program cut after 4 data bits, sector erase cut after two address bytes.
    frame_begin(); xfer(8'h02, d); send_addr(24'(2*SBYTES + 4));
    xfer_bits(8'h00, 4, d); frame_end();
    get_status(s);
    chk("R7 no busy after aborted program", {24'd0, s}, 32'h01);
    read_cmp("R7 aborted program", 24'(2*SBYTES + 4), 1);
    frame_begin(); xfer(8'h20, d); xfer(8'h00, d); xfer(8'h00, d); frame_end();
    get_status(s);
    chk("R7 no busy after aborted erase", {24'd0, s}, 32'h01);
    read_cmp("R7 aborted erase", 24'd5, 1);

    // Write protect.
    wp_n = 1'b0;
    do_prog(24'd0, 8'h00);
    get_status(s);
    chk("R8 protected program not busy", {24'd0, s}, 32'h01);
    do_serase(24'(2*SBYTES));
    do_cerase();
    get_status(s);
    chk("R8 protected erase not busy", {24'd0, s}, 32'h01);
    read_cmp("R8 protected byte 0", 24'd0, 1);
    read_cmp("R8 protected sector 2", 24'(2*SBYTES + 4), 1);
    wp_n = 1'b1;

    // Busy: only status accepted.
    do_serase(24'(2*SBYTES));
    for (int i = 0; i < MEM; i++) if (sect(i) == 2) em[i] = 8'hFF;
    frame_begin(); xfer(8'h03, d); send_addr(24'(2*SBYTES + 4));
    for (int k = 0; k < 2; k++) begin
      xfer(8'h00, d);
      chk("R9 read ignored while busy", {24'd0, d}, 32'h00);
    end
    frame_end();
    do_prog(24'(2*SBYTES + 9), 8'h00);
    wait_ready();
    read_cmp("R9 program ignored while busy", 24'(2*SBYTES + 9), 1);

    // Reset during a chip erase.
    do_cerase();
    for (int i = 0; i < MEM; i++) em[i] = 8'hFF;
    half();
    reset_n = 1'b0; repeat (4) @(posedge clk); #1;
    chk("R10 so released in reset", {31'd0, so_oe}, 32'd0);
    reset_n = 1'b1; half();
    get_status(s);
    chk("R10 ready after reset", {24'd0, s}, 32'h01);
    ref_a = seed & 0;
    read_cmp("R6 chip erase content", 24'(ref_a + 60), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule